// File: doc/BRIEF.md
# Single-wire slave ROM command responder

This block is the addressing layer of a slave on a single-wire, open-drain bus. It owns a 64-bit identity code and, after every bus reset, receives one 8-bit ROM command, then carries out the exchange that command calls for. Depending on the command, it reads the code out, compares it against a code sent by the master, or selects itself unconditionally. It also takes part in the bitwise search that lets a master find every code on the bus, and in a second search in which only slaves with a raised alarm answer. When addressing succeeds it raises `selected`, and a function-command layer takes over the bus traffic.

A bit-slot front end, not part of this block, decodes line activity into single-cycle events. These are a bus reset, a write slot carrying the bit the master sent, and the start of a read slot. The events carry no back-pressure: the block accepts an event in every cycle, with no ready signal, and the front end never has to wait. In return the block answers each read slot with `tx_bit`, where 0 means pull the line low and 1 means release it. On the wired-AND bus, releasing the line is how a one is sent.

The identity code is built from two parameters: a family byte and a 48-bit serial number. The CRC byte is computed from them at elaboration.

Top module: `sw_rom_responder`

## Requirements
- R1: The identity code has the family byte (default 28h) in bits 7:0 and the serial number in bits 55:8. Bits 63:56 hold a CRC-8 over bits 0 to 55, taken least significant bit first with a zero start value. For each input bit the CRC step is: feedback = crc[0] xor bit, shift crc right by one, and if the feedback is 1 xor the result with 8Ch (the polynomial x^8+x^5+x^4+1).
- R2: After a reset event, the next 8 write events form the ROM command byte, least significant bit first. Read events during command reception return 1.
- R3: Command 33h: the next 64 read events return code bits 0 to 63 in order, and `selected` goes high in the cycle after the 64th.
- R4: Command 55h: the next 64 write events are compared with code bits 0 to 63. If all of them match, `selected` goes high in the cycle after the 64th. On any mismatch the device never selects, and every later read returns 1 until a reset event.
- R5: Command CCh raises `selected` in the cycle after the command byte's last bit. `selected` then stays high, whatever reads and writes follow, until a reset event.
- R6: Command F0h: for each bit i from 0 to 63, the first read returns code bit i and the second read returns its inverse. The following write is then compared with code bit i. On a match the search moves on to bit i+1. On a mismatch the device drops out, and every read returns 1 until a reset event.
- R7: Command ECh behaves like F0h when `alarm_flag` is high in the cycle the command byte completes. Otherwise the device drops out: reads return 1 and it never selects.
- R8: After a search completes all 64 bits, `selected` stays low. Reads return 1 and writes have no effect until a reset event.
- R9: Any command byte other than 33h, 55h, CCh, F0h or ECh puts the device idle. While idle, reads return 1 and `selected` stays low until a reset event.
- R10: A reset event, in any state, drives `selected` low and `tx_bit` to 1 in the next cycle, and restarts command reception.
- R11: `tx_bit` changes only in the cycle after a read event or a reset event, and holds its value otherwise. Write events never change it.
- R12: When a reset event and a read event arrive in the same cycle, the reset wins: `tx_bit` is 1 and the device is back in command reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| ev_reset | input | 1 | One-cycle pulse: bus reset seen |
| ev_wr | input | 1 | One-cycle pulse: master write slot completed |
| ev_wr_bit | input | 1 | Bit value of the write slot, valid with ev_wr |
| ev_rd | input | 1 | One-cycle pulse: master started a read slot |
| alarm_flag | input | 1 | Alarm condition from the function layer |
| tx_bit | output | 1 | Bit to drive in the current read slot (0 = pull low, 1 = release) |
| selected | output | 1 | Device addressed; function-command layer owns the bus |

## Verification
The hardest situation to reach is the drop-out in the middle of a search. The device must have answered several true/complement pairs correctly before the master writes the opposite bit, and every read after that must return 1. The bench reaches it by running a search that follows the code for five bits and then writes the inverse of the sixth bit. A complete 64-bit search is driven the same way, taking the master's bit from its own copy of the code, so that the post-search lockout can be checked. A reset arriving in the same cycle as a read slot is driven directly as well.

// File: rtl/swr_pkg.sv
package swr_pkg;
  localparam int FAM_W  = 8;
  localparam int SER_W  = 48;
  localparam int CRC_W  = 8;
  localparam int BODY_W = FAM_W + SER_W;
  localparam int CODE_W = BODY_W + CRC_W;

  localparam logic [7:0] CMD_READ   = 8'h33;
  localparam logic [7:0] CMD_MATCH  = 8'h55;
  localparam logic [7:0] CMD_SKIP   = 8'hCC;
  localparam logic [7:0] CMD_SEARCH = 8'hF0;
  localparam logic [7:0] CMD_ALARM  = 8'hEC;

  typedef enum logic [2:0] {
    ST_CMD, ST_READ, ST_MATCH, ST_SEARCH, ST_SEL, ST_DONE, ST_IDLE
  } swr_state_e;

  typedef enum logic [1:0] {
    PH_TRUE, PH_CMPL, PH_DIR
  } srch_phase_e;

  // reflected CRC-8, polynomial x^8+x^5+x^4+1, LSB first, zero start
  function automatic logic [CRC_W-1:0] crc8_lsb(input logic [BODY_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = 0; i < BODY_W; i++) begin
      fb = c[0] ^ d[i];
      c  = {1'b0, c[CRC_W-1:1]};
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction
endpackage

// File: rtl/swr_code_rom.sv
module swr_code_rom
  import swr_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY_CODE = 8'h28,
  parameter logic [SER_W-1:0] SERIAL_NUM  = 48'h0000_1234_ABCD
) (
  output logic [CODE_W-1:0] code
);
  localparam logic [BODY_W-1:0] BODY = {SERIAL_NUM, FAMILY_CODE};
  localparam logic [CRC_W-1:0]  CHK  = crc8_lsb(BODY);

  assign code = {CHK, BODY};
endmodule

// File: rtl/swr_cmd_rx.sv
module swr_cmd_rx #(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             en,
  input  logic             wr_valid,
  input  logic             wr_bit,
  output logic             cmd_valid,
  output logic [CMD_W-1:0] cmd_byte
);
  localparam int CNT_W = $clog2(CMD_W);

  logic [CMD_W-2:0] shreg;
  logic [CNT_W-1:0] cnt;
  logic             take;

  assign take      = en & wr_valid;
  assign cmd_byte  = {wr_bit, shreg};
  assign cmd_valid = take && (cnt == CNT_W'(CMD_W-1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (take) begin
      shreg <= {wr_bit, shreg[CMD_W-2:1]};
      cnt   <= cmd_valid ? '0 : cnt + CNT_W'(1);
    end
  end

  AST_CMD_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0)); // R10

  AST_CMD_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !clear) |=> $stable(cnt)); // R2
endmodule

// File: rtl/sw_rom_responder.sv
module sw_rom_responder
  import swr_pkg::*;
#(
  parameter logic [7:0]  FAMILY_CODE = 8'h28,
  parameter logic [47:0] SERIAL_NUM  = 48'h0000_1234_ABCD
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_reset,
  input  logic ev_wr,
  input  logic ev_wr_bit,
  input  logic ev_rd,
  input  logic alarm_flag,
  output logic tx_bit,
  output logic selected
);
  localparam int IDX_W = $clog2(CODE_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CODE_W-1);

  logic [CODE_W-1:0] code;
  swr_state_e        st;
  srch_phase_e       ph;
  logic [IDX_W-1:0]  idx;
  logic              cur_bit;
  logic              idx_last;
  logic              cmd_valid;
  logic [7:0]        cmd_byte;

  swr_code_rom #(
    .FAMILY_CODE(FAMILY_CODE),
    .SERIAL_NUM (SERIAL_NUM)
  ) u_code (
    .code(code)
  );

  swr_cmd_rx #(.CMD_W(8)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (ev_reset),
    .en       (st == ST_CMD),
    .wr_valid (ev_wr),
    .wr_bit   (ev_wr_bit),
    .cmd_valid(cmd_valid),
    .cmd_byte (cmd_byte)
  );

  assign cur_bit  = code[idx];
  assign idx_last = (idx == IDX_LAST);
  assign selected = (st == ST_SEL);

  always_ff @(posedge clk) begin
    if (!rst_n || ev_reset) begin
      st     <= ST_CMD;
      ph     <= PH_TRUE;
      idx    <= '0;
      tx_bit <= 1'b1;
    end else begin
      if (ev_rd) tx_bit <= 1'b1;
      case (st)
        ST_CMD: if (cmd_valid) begin
          idx <= '0;
          ph  <= PH_TRUE;
          case (cmd_byte)
            CMD_READ:   st <= ST_READ;
            CMD_MATCH:  st <= ST_MATCH;
            CMD_SKIP:   st <= ST_SEL;
            CMD_SEARCH: st <= ST_SEARCH;
            CMD_ALARM:  st <= alarm_flag ? ST_SEARCH : ST_IDLE;
            default:    st <= ST_IDLE;
          endcase
        end
        ST_READ: if (ev_rd) begin
          tx_bit <= cur_bit;
          idx    <= idx + IDX_W'(1);
          if (idx_last) st <= ST_SEL;
        end
        ST_MATCH: if (ev_wr) begin
          if (ev_wr_bit != cur_bit) st <= ST_IDLE;
          else if (idx_last)        st <= ST_SEL;
          else                      idx <= idx + IDX_W'(1);
        end
        ST_SEARCH: begin
          case (ph)
            PH_TRUE: if (ev_rd) begin
              tx_bit <= cur_bit;
              ph     <= PH_CMPL;
            end
            PH_CMPL: if (ev_rd) begin
              tx_bit <= ~cur_bit;
              ph     <= PH_DIR;
            end
            PH_DIR: if (ev_wr) begin
              if (ev_wr_bit != cur_bit) st <= ST_IDLE;
              else if (idx_last)        st <= ST_DONE;
              else begin
                idx <= idx + IDX_W'(1);
                ph  <= PH_TRUE;
              end
            end
            default: ph <= PH_TRUE;
          endcase
        end
        default: ;
      endcase
    end
  end

  AST_RESET_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reset |=> (!selected && tx_bit && st == ST_CMD)); // R10

  AST_RESET_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_reset && ev_rd) |=> tx_bit); // R12

  AST_IDLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && ev_rd && !ev_reset) |=> tx_bit); // R9

  AST_SEARCH_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SEARCH && ph == PH_CMPL && ev_rd && !ev_reset)
      |=> (tx_bit != $past(tx_bit))); // R6

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DONE && !ev_reset) |=> (st == ST_DONE && !selected)); // R8

  AST_WRITE_KEEPS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_rd && !ev_reset) |=> $stable(tx_bit)); // R11

  AST_SEL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (selected && !ev_reset) |=> selected); // R5
endmodule

// File: tb/sim_sw_rom_responder.sv
module sim_sw_rom_responder;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0]  FAM = 8'h28;
  localparam logic [47:0] SER = 48'hA1B2_C3D4_E5F6;

  // {cmd[7:0], alarm, expected selected, expected read value}
  localparam logic [10:0] VEC [0:6] = '{
    {8'hCC, 1'b0, 1'b1, 1'b1},
    {8'h33, 1'b0, 1'b0, 1'b0},
    {8'hF0, 1'b0, 1'b0, 1'b0},
    {8'hEC, 1'b1, 1'b0, 1'b0},
    {8'hEC, 1'b0, 1'b0, 1'b1},
    {8'hA5, 1'b0, 1'b0, 1'b1},
    {8'h55, 1'b0, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_reset = 1'b0, ev_wr = 1'b0, ev_wr_bit = 1'b0, ev_rd = 1'b0;
  logic alarm_flag = 1'b0;
  logic tx_bit, selected;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] exp_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  sw_rom_responder #(.FAMILY_CODE(FAM), .SERIAL_NUM(SER)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_reset(ev_reset), .ev_wr(ev_wr),
    .ev_wr_bit(ev_wr_bit), .ev_rd(ev_rd), .alarm_flag(alarm_flag),
    .tx_bit(tx_bit), .selected(selected)
  );

  function automatic logic [7:0] ref_crc(input logic [55:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      if (c[0] ^ d[i]) c = {1'b0, c[7:1]} ^ 8'h8C;
      else             c = {1'b0, c[7:1]};
    end
    return c;
  endfunction

  function automatic string tag_of(input logic [7:0] c);
    case (c)
      8'hCC: return "R5";
      8'h33: return "R3";
      8'h55: return "R4";
      8'hF0: return "R6";
      8'hEC: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_reset;
    @(negedge clk); ev_reset = 1'b1;
    @(negedge clk); ev_reset = 1'b0;
  endtask

  task automatic wr_slot(input logic b);
    @(negedge clk); ev_wr = 1'b1; ev_wr_bit = b;
    @(negedge clk); ev_wr = 1'b0;
  endtask

  task automatic rd_slot(output logic b);
    @(negedge clk); ev_rd = 1'b1;
    @(negedge clk); ev_rd = 1'b0; b = tx_bit;
  endtask

  task automatic send_cmd(input logic [7:0] c);
    for (int i = 0; i < 8; i++) wr_slot(c[i]);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic b, b2;
    logic [63:0] got;
    exp_code = {ref_crc({SER, FAM}), SER, FAM};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset tx", {63'd0, tx_bit}, 64'd1);
    chk("R10 reset selected", {63'd0, selected}, 64'd0);

    // table of command outcomes
    for (int v = 0; v < 7; v++) begin
      bus_reset();
      alarm_flag = VEC[v][2];
      send_cmd(VEC[v][10:3]);
      @(negedge clk);
      chk({tag_of(VEC[v][10:3]), " selected after cmd"}, {63'd0, selected}, {63'd0, VEC[v][1]});
      rd_slot(b);
      chk({tag_of(VEC[v][10:3]), " first read"}, {63'd0, b}, {63'd0, VEC[v][0]});
    end
    alarm_flag = 1'b0;

    // R1 / R3: full code readout
    bus_reset(); send_cmd(8'h33);
    for (int i = 0; i < 64; i++) begin rd_slot(b); got[i] = b; end
    chk("R3 code readout", got, exp_code);
    chk("R1 family byte", {56'd0, got[7:0]}, {56'd0, FAM});
    chk("R1 crc byte", {56'd0, got[63:56]}, {56'd0, ref_crc(got[55:0])});
    chk("R3 selected after 64 reads", {63'd0, selected}, 64'd1);

    // R11: write does not move tx
    bus_reset(); send_cmd(8'h33);
    rd_slot(b);
    wr_slot(1'b1);
    @(negedge clk);
    chk("R11 tx held over write", {63'd0, tx_bit}, {63'd0, exp_code[0]});

    // R4: good match
    bus_reset(); send_cmd(8'h55);
    for (int i = 0; i < 63; i++) wr_slot(exp_code[i]);
    chk("R4 not selected before last bit", {63'd0, selected}, 64'd0);
    wr_slot(exp_code[63]);
    chk("R4 match selects", {63'd0, selected}, 64'd1);

    // R4: mismatch at bit 40
    bus_reset(); send_cmd(8'h55);
    for (int i = 0; i < 64; i++) wr_slot(i == 40 ? ~exp_code[i] : exp_code[i]);
    chk("R4 mismatch not selected", {63'd0, selected}, 64'd0);
    rd_slot(b);
    chk("R4 mismatch read released", {63'd0, b}, 64'd1);

    // R6 / R8: full search
    bus_reset(); send_cmd(8'hF0);
    got = '0;
    for (int i = 0; i < 64; i++) begin
      rd_slot(b); rd_slot(b2);
      got[i] = b;
      if (b2 !== ~exp_code[i]) chk("R6 complement bit", {63'd0, b2}, {63'd0, ~exp_code[i]});
      wr_slot(exp_code[i]);
    end
    chk("R6 search true bits", got, exp_code);
    chk("R8 search end not selected", {63'd0, selected}, 64'd0);
    wr_slot(1'b0);
    rd_slot(b);
    chk("R8 read after search", {63'd0, b}, 64'd1);
    chk("R8 still not selected", {63'd0, selected}, 64'd0);

    // R6: drop out at bit 5
    bus_reset(); send_cmd(8'hF0);
    for (int i = 0; i < 5; i++) begin rd_slot(b); rd_slot(b2); wr_slot(exp_code[i]); end
    rd_slot(b); rd_slot(b2);
    chk("R6 bit5 true", {63'd0, b}, {63'd0, exp_code[5]});
    chk("R6 bit5 complement", {63'd0, b2}, {63'd0, ~exp_code[5]});
    wr_slot(~exp_code[5]);
    rd_slot(b);
    chk("R6 dropped out read", {63'd0, b}, 64'd1);
    rd_slot(b);
    chk("R6 dropped out second read", {63'd0, b}, 64'd1);

    // R7: alarm search with flag, full
    bus_reset(); alarm_flag = 1'b1; send_cmd(8'hEC); alarm_flag = 1'b0;
    got = '0;
    for (int i = 0; i < 64; i++) begin
      rd_slot(b); rd_slot(b2); got[i] = b; wr_slot(exp_code[i]);
    end
    chk("R7 alarm search bits", got, exp_code);
    chk("R7 alarm search not selected", {63'd0, selected}, 64'd0);

    // R10: reset mid readout, then skip
    bus_reset(); send_cmd(8'h33);
    for (int i = 0; i < 10; i++) rd_slot(b);
    bus_reset(); send_cmd(8'hCC);
    chk("R10 restart after mid reset", {63'd0, selected}, 64'd1);
    bus_reset();
    chk("R10 reset clears selected", {63'd0, selected}, 64'd0);

    // R12: reset and read together
    send_cmd(8'h33);
    @(negedge clk); ev_reset = 1'b1; ev_rd = 1'b1;
    @(negedge clk); ev_reset = 1'b0; ev_rd = 1'b0;
    chk("R12 reset wins tx", {63'd0, tx_bit}, 64'd1);
    send_cmd(8'hCC);
    chk("R12 command reception restarted", {63'd0, selected}, 64'd1);

    // R2: read during command reception
    bus_reset();
    for (int i = 0; i < 4; i++) wr_slot(8'hCC >> i);
    rd_slot(b);
    chk("R2 read during command", {63'd0, b}, 64'd1);
    for (int i = 4; i < 8; i++) wr_slot(8'hCC >> i);
    chk("R2 command assembled lsb first", {63'd0, selected}, 64'd1);

    // R5: selection survives traffic
    for (int i = 0; i < 8; i++) wr_slot(1'b0);
    rd_slot(b);
    chk("R5 selected sticky", {63'd0, selected}, 64'd1);

    finish_run();
  end
endmodule